// File: doc/BRIEF.md
# Far Transfer Privilege Checker

This block judges a far JMP or CALL before the new code segment is loaded. A request gives the caller's current privilege, whether the transfer is a CALL, the selector and offset taken from the instruction, and the descriptor that the selector names. When that descriptor is an ordinary code segment, the block settles the transfer in one step. When it is a call gate, the block asks for the descriptor named by the gate's own selector through a fetch port. It then applies the privilege rule that involves the target, the caller and the gate.

The result is one of four outcomes: a direct transfer, a gate transfer at the same level, a gate transfer that raises privilege, or a fault. Every result also gives the new code selector, the entry offset, the count of stack dwords to copy and the privilege that the caller runs at afterwards. Copying stack words, switching stacks and returns are left to other logic, which acts on these outputs.

Top module: `cg_far_xfer_check`

## Requirements
- R1: Descriptor bits are decoded as follows: bit 47 present, bits 46:45 DPL, bit 44 set for a code or data segment. For such a segment, bit 43 set means code and bit 42 set means conforming. A present non-conforming code segment with DPL equal to the CPL, reached through a selector whose RPL (bits 1:0) is no greater than the CPL, gives kind 0 (direct). The outputs are then cs = selector bits 15:2 followed by the CPL, offset = the request offset, count 0 and cpl unchanged.
- R2: A present conforming code segment with DPL no greater than the CPL gives kind 0 whatever the RPL. The cpl output stays the caller's CPL, and cs carries that CPL in bits 1:0.
- R3: A direct request faults (kind 3) in each of these cases: a non-conforming code segment whose DPL differs from the CPL or whose RPL exceeds the CPL, a conforming segment whose DPL exceeds the CPL, a data segment, a segment that is not present, and any system descriptor that is not a call gate.
- R4: A call gate is a descriptor with bit 44 clear, bits 42:40 = 100 and bits 39:37 = 000. With EPL = max(CPL, RPL), a gate that is not present, or whose DPL is below the EPL, faults at once and issues no fetch.
- R5: An accepted gate issues a fetch for the selector made of gate bits 31:18 with bits 1:0 zero. The fetched target must be a present code segment whose DPL is no greater than the EPL and no greater than the CPL. Otherwise the result is kind 3.
- R6: On a gate transfer the entry offset comes from the gate and not from the request. When gate bit 43 is set, the offset is bits 63:48 followed by bits 15:0. When bit 43 is clear, the upper half of the offset is zero. The cs output is gate bits 31:18 followed by the new CPL, so the RPL held in the gate's selector has no effect.
- R7: A CALL through a gate to a non-conforming target whose DPL is below the CPL gives kind 2 (raise). The new cpl is the target DPL, and count is the 5-bit gate field at bits 36:32.
- R8: A JMP through a gate to a more privileged non-conforming target faults. A JMP through a gate to a non-conforming target at the CPL gives kind 1 with count 0.
- R9: A gate to a conforming target that passes R5 gives kind 1, keeps the caller's CPL and has count 0. Kind 1 with count 0 is also the result for a non-conforming target at the caller's level.
- R10: A direct or immediately faulting request has res_valid high for one cycle, starting in the cycle after the request edge. A gate request keeps busy and fetch_req high, with fetch_sel stable, until fetch_valid is sampled, and its result follows in the next cycle. A request made while busy is ignored.
- R11: A fault result drives cs, offset and count to zero, and cpl to the caller's CPL.
- R12: After a synchronous reset, res_valid, busy and fetch_req are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_is_call | input | 1 | 1 for CALL, 0 for JMP |
| req_cpl | input | 2 | Caller current privilege |
| req_sel | input | 16 | Selector from the instruction |
| req_offset | input | 32 | Offset from the instruction |
| req_desc | input | 64 | Descriptor named by req_sel |
| busy | output | 1 | A gate target fetch is pending |
| fetch_req | output | 1 | Target descriptor fetch request |
| fetch_sel | output | 16 | Selector to fetch |
| fetch_valid | input | 1 | Fetched descriptor is present on fetch_desc |
| fetch_desc | input | 64 | Fetched target descriptor |
| res_valid | output | 1 | Result strobe |
| res_kind | output | 2 | 0 direct, 1 gate same level, 2 gate raise, 3 fault |
| res_cs | output | 16 | New code selector |
| res_offset | output | 32 | Entry offset |
| res_count | output | 5 | Stack dwords to copy |
| res_cpl | output | 2 | Privilege after the transfer |

## Verification
The bench targets the mixed rule through a gate. One case passes the gate check on RPL but reaches a target less privileged than the caller, and it must fault. A design that compared the target only against the EPL would let it through at the lower level. A JMP through a gate to a more privileged target must also fault, where a careless design would raise privilege without a CALL. A 16-bit gate carrying junk in its upper offset half, and a gate selector with a non-zero RPL, catch designs that leak those bits into the entry point or the new selector. A gate rejected on the EPL must produce no fetch, and a request made while a fetch is pending must produce no second result. Both would otherwise show up as an extra fetch or an unmatched result.

// File: rtl/cg_xfer_pkg.sv
package cg_xfer_pkg;

    localparam int SEL_W  = 16;
    localparam int OFF_W  = 32;
    localparam int CNT_W  = 5;
    localparam int PL_W   = 2;
    localparam int DESC_W = 64;
    localparam int IDX_W  = SEL_W - PL_W;
    localparam int HALF_W = OFF_W / 2;

    typedef enum logic [1:0] {
        XK_DIRECT = 2'd0,
        XK_GATE   = 2'd1,
        XK_RAISE  = 2'd2,
        XK_FAULT  = 2'd3
    } xfer_kind_e;

    typedef struct packed {
        logic              present;
        logic              is_user;
        logic              is_code;
        logic              conforming;
        logic              is_gate;
        logic [PL_W-1:0]   dpl;
        logic [IDX_W-1:0]  gate_idx;
        logic [OFF_W-1:0]  gate_off;
        logic [CNT_W-1:0]  gate_cnt;
    } desc_info_t;

    typedef struct packed {
        xfer_kind_e        kind;
        logic [SEL_W-1:0]  cs;
        logic [OFF_W-1:0]  offset;
        logic [CNT_W-1:0]  count;
        logic [PL_W-1:0]   cpl;
    } xfer_res_t;

    function automatic desc_info_t decode_desc(input logic [DESC_W-1:0] d);
        desc_info_t i;
        i.present    = d[47];
        i.dpl        = d[46:45];
        i.is_user    = d[44];
        i.is_code    = d[44] & d[43];
        i.conforming = d[42];
        i.is_gate    = ~d[44] && (d[42:40] == 3'b100) && (d[39:37] == 3'b000);
        i.gate_idx   = d[31:18];
        i.gate_cnt   = d[36:32];
        i.gate_off   = d[43] ? {d[63:48], d[15:0]} : {{HALF_W{1'b0}}, d[15:0]};
        return i;
    endfunction

    function automatic logic [PL_W-1:0] pl_max(input logic [PL_W-1:0] a,
                                               input logic [PL_W-1:0] b);
        return (a > b) ? a : b;
    endfunction

    function automatic xfer_res_t fault_res(input logic [PL_W-1:0] cpl);
        xfer_res_t r;
        r.kind   = XK_FAULT;
        r.cs     = '0;
        r.offset = '0;
        r.count  = '0;
        r.cpl    = cpl;
        return r;
    endfunction

endpackage

// File: rtl/cg_direct_judge.sv
module cg_direct_judge
    import cg_xfer_pkg::*;
(
    input  logic [PL_W-1:0]  cpl,
    input  logic [SEL_W-1:0] sel,
    input  logic [OFF_W-1:0] off,
    input  desc_info_t       info,
    output xfer_res_t        res
);
    logic [PL_W-1:0] rpl;
    logic            level_ok;

    assign rpl = sel[PL_W-1:0];

    always_comb begin
        if (info.conforming)
            level_ok = (info.dpl <= cpl);
        else
            level_ok = (info.dpl == cpl) && (rpl <= cpl);
    end

    always_comb begin
        if (info.present && info.is_code && level_ok) begin
            res.kind   = XK_DIRECT;
            res.cs     = {sel[SEL_W-1:PL_W], cpl};
            res.offset = off;
            res.count  = '0;
            res.cpl    = cpl;
        end else begin
            res = fault_res(cpl);
        end
    end
endmodule

// File: rtl/cg_gate_entry.sv
module cg_gate_entry
    import cg_xfer_pkg::*;
(
    input  logic [PL_W-1:0] cpl,
    input  logic [PL_W-1:0] rpl,
    input  desc_info_t      info,
    output logic            enter,
    output logic [PL_W-1:0] epl
);
    assign epl   = pl_max(cpl, rpl);
    assign enter = info.is_gate && info.present && (epl <= info.dpl);
endmodule

// File: rtl/cg_target_judge.sv
module cg_target_judge
    import cg_xfer_pkg::*;
(
    input  logic             is_call,
    input  logic [PL_W-1:0]  cpl,
    input  logic [PL_W-1:0]  epl,
    input  logic [IDX_W-1:0] gate_idx,
    input  logic [OFF_W-1:0] gate_off,
    input  logic [CNT_W-1:0] gate_cnt,
    input  desc_info_t       tinfo,
    output xfer_res_t        res
);
    logic            target_ok;
    logic            raises;
    logic [PL_W-1:0] new_cpl;

    assign target_ok = tinfo.present && tinfo.is_code &&
                       (tinfo.dpl <= epl) && (tinfo.dpl <= cpl);
    assign raises    = ~tinfo.conforming && (tinfo.dpl < cpl);
    assign new_cpl   = tinfo.conforming ? cpl : tinfo.dpl;

    always_comb begin
        if (target_ok && !(raises && !is_call)) begin
            res.kind   = raises ? XK_RAISE : XK_GATE;
            res.cs     = {gate_idx, new_cpl};
            res.offset = gate_off;
            res.count  = raises ? gate_cnt : '0;
            res.cpl    = new_cpl;
        end else begin
            res = fault_res(cpl);
        end
    end
endmodule

// File: rtl/cg_far_xfer_check.sv
module cg_far_xfer_check
    import cg_xfer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_is_call,
    input  logic [PL_W-1:0]   req_cpl,
    input  logic [SEL_W-1:0]  req_sel,
    input  logic [OFF_W-1:0]  req_offset,
    input  logic [DESC_W-1:0] req_desc,
    output logic              busy,
    output logic              fetch_req,
    output logic [SEL_W-1:0]  fetch_sel,
    input  logic              fetch_valid,
    input  logic [DESC_W-1:0] fetch_desc,
    output logic              res_valid,
    output logic [1:0]        res_kind,
    output logic [SEL_W-1:0]  res_cs,
    output logic [OFF_W-1:0]  res_offset,
    output logic [CNT_W-1:0]  res_count,
    output logic [PL_W-1:0]   res_cpl
);
    typedef enum logic {ST_IDLE, ST_FETCH} state_e;

    state_e           state;
    desc_info_t       req_info;
    desc_info_t       tgt_info;
    xfer_res_t        dir_res;
    xfer_res_t        tgt_res;
    xfer_res_t        res_q;
    logic             res_valid_q;
    logic             gate_enter;
    logic [PL_W-1:0]  req_epl;
    logic             cap_call;
    logic [PL_W-1:0]  cap_cpl;
    logic [PL_W-1:0]  cap_epl;
    logic [IDX_W-1:0] cap_idx;
    logic [OFF_W-1:0] cap_off;
    logic [CNT_W-1:0] cap_cnt;

    assign req_info = decode_desc(req_desc);
    assign tgt_info = decode_desc(fetch_desc);

    cg_direct_judge u_direct (
        .cpl  (req_cpl),
        .sel  (req_sel),
        .off  (req_offset),
        .info (req_info),
        .res  (dir_res)
    );

    cg_gate_entry u_entry (
        .cpl   (req_cpl),
        .rpl   (req_sel[PL_W-1:0]),
        .info  (req_info),
        .enter (gate_enter),
        .epl   (req_epl)
    );

    cg_target_judge u_target (
        .is_call  (cap_call),
        .cpl      (cap_cpl),
        .epl      (cap_epl),
        .gate_idx (cap_idx),
        .gate_off (cap_off),
        .gate_cnt (cap_cnt),
        .tinfo    (tgt_info),
        .res      (tgt_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            res_valid_q <= 1'b0;
            res_q       <= '0;
            cap_call    <= 1'b0;
            cap_cpl     <= '0;
            cap_epl     <= '0;
            cap_idx     <= '0;
            cap_off     <= '0;
            cap_cnt     <= '0;
        end else begin
            res_valid_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        cap_call <= req_is_call;
                        cap_cpl  <= req_cpl;
                        if (gate_enter) begin
                            cap_epl <= req_epl;
                            cap_idx <= req_info.gate_idx;
                            cap_off <= req_info.gate_off;
                            cap_cnt <= req_info.gate_cnt;
                            state   <= ST_FETCH;
                        end else begin
                            res_q       <= dir_res;
                            res_valid_q <= 1'b1;
                        end
                    end
                end
                ST_FETCH: begin
                    if (fetch_valid) begin
                        res_q       <= tgt_res;
                        res_valid_q <= 1'b1;
                        state       <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy       = (state == ST_FETCH);
    assign fetch_req  = (state == ST_FETCH);
    assign fetch_sel  = {cap_idx, {PL_W{1'b0}}};
    assign res_valid  = res_valid_q;
    assign res_kind   = res_q.kind;
    assign res_cs     = res_q.cs;
    assign res_offset = res_q.offset;
    assign res_count  = res_q.count;
    assign res_cpl    = res_q.cpl;

    // R8: privilege is raised only by a CALL, and only to a lower number
    assert_raise_only_call_R8: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_kind == XK_RAISE) |-> (cap_call && res_cpl < cap_cpl));

    // R2: results that do not raise keep the caller's level
    assert_keep_cpl_R2: assert property (@(posedge clk) disable iff (rst)
        (res_valid && (res_kind == XK_DIRECT || res_kind == XK_GATE)) |-> (res_cpl == cap_cpl));

    // R6: a granted selector carries the new privilege as its RPL
    assert_cs_rpl_R6: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_kind != XK_FAULT) |-> (res_cs[PL_W-1:0] == res_cpl));

    // R11: fault results are cleared apart from the caller's level
    assert_fault_clear_R11: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_kind == XK_FAULT) |->
        (res_cs == '0 && res_offset == '0 && res_count == '0 && res_cpl == cap_cpl));

    // R10: a pending fetch holds its selector until answered
    assert_fetch_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (fetch_req && !fetch_valid) |=> (fetch_req && $stable(fetch_sel)));

    // R10: no result is produced while a fetch is still outstanding
    assert_no_early_result_R10: assert property (@(posedge clk) disable iff (rst)
        (fetch_req && !fetch_valid) |=> !res_valid);
endmodule

// File: tb/cg_far_xfer_check_test.sv
module cg_far_xfer_check_test;

    typedef struct {
        logic [1:0]  kind;
        logic [15:0] cs;
        logic [31:0] off;
        logic [4:0]  cnt;
        logic [1:0]  cpl;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_is_call = 1'b0;
    logic [1:0]  req_cpl = '0;
    logic [15:0] req_sel = '0;
    logic [31:0] req_offset = '0;
    logic [63:0] req_desc = '0;
    logic        busy;
    logic        fetch_req;
    logic [15:0] fetch_sel;
    logic        fetch_valid = 1'b0;
    logic [63:0] fetch_desc = '0;
    logic        res_valid;
    logic [1:0]  res_kind;
    logic [15:0] res_cs;
    logic [31:0] res_offset;
    logic [4:0]  res_count;
    logic [1:0]  res_cpl;

    int   total = 0;
    int   bad = 0;
    int   fetch_cnt = 0;
    bit   done = 1'b0;
    logic [63:0] tgt_desc = '0;
    exp_t sb[$];

    always #5 clk = ~clk;

    cg_far_xfer_check uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_is_call(req_is_call), .req_cpl(req_cpl),
        .req_sel(req_sel), .req_offset(req_offset), .req_desc(req_desc),
        .busy(busy), .fetch_req(fetch_req), .fetch_sel(fetch_sel),
        .fetch_valid(fetch_valid), .fetch_desc(fetch_desc),
        .res_valid(res_valid), .res_kind(res_kind), .res_cs(res_cs),
        .res_offset(res_offset), .res_count(res_count), .res_cpl(res_cpl)
    );

    function automatic logic [63:0] code_d(bit p, logic [1:0] dpl, bit conf);
        return {8'h00, 4'hC, 4'h0, p, dpl, 1'b1, 1'b1, conf, 2'b11, 8'h13, 16'h1BCC, 16'hEE3D};
    endfunction

    function automatic logic [63:0] data_d(bit p, logic [1:0] dpl);
        return {8'h00, 4'hC, 4'h0, p, dpl, 1'b1, 1'b0, 3'b011, 8'h08, 16'h3EA0, 16'h7B3E};
    endfunction

    function automatic logic [63:0] gate_d(bit p, logic [1:0] dpl, bit w32,
                                           logic [15:0] s, logic [31:0] o, logic [4:0] c);
        return {o[31:16], p, dpl, 1'b0, w32, 3'b100, 3'b000, c, s, o[15:0]};
    endfunction

    function automatic exp_t model(bit call, logic [1:0] cpl, logic [15:0] s,
                                   logic [31:0] o, logic [63:0] d, logic [63:0] td);
        exp_t r;
        logic [1:0] rpl, epl, tdpl, nc;
        bit ok, raise;
        r.kind = 2'd3; r.cs = '0; r.off = '0; r.cnt = '0; r.cpl = cpl; r.tag = "";
        rpl = s[1:0];
        epl = (cpl > rpl) ? cpl : rpl;
        if (d[44]) begin
            ok = d[47] && d[43] && (d[42] ? (d[46:45] <= cpl)
                                          : (d[46:45] == cpl && rpl <= cpl));
            if (ok) begin
                r.kind = 2'd0; r.cs = {s[15:2], cpl}; r.off = o;
            end
        end else if (d[42:37] == 6'b100000 && d[47] && epl <= d[46:45]) begin
            tdpl = td[46:45];
            if (td[47] && td[44] && td[43] && tdpl <= epl && tdpl <= cpl) begin
                raise = !td[42] && tdpl < cpl;
                if (!(raise && !call)) begin
                    nc = td[42] ? cpl : tdpl;
                    r.kind = raise ? 2'd2 : 2'd1;
                    r.cs   = {d[31:18], nc};
                    r.off  = d[43] ? {d[63:48], d[15:0]} : {16'h0, d[15:0]};
                    r.cnt  = raise ? d[36:32] : 5'd0;
                    r.cpl  = nc;
                end
            end
        end
        return r;
    endfunction

    task automatic check(bit cond, string what, string act, string expv);
        total++;
        if (!cond) begin
            bad++;
            $display("FAIL %s actual=%s expected=%s", what, act, expv);
        end
    endtask

    task automatic do_req(bit call, logic [1:0] cpl, logic [15:0] s, logic [31:0] o,
                          logic [63:0] d, logic [63:0] td, bit poke, string tag);
        exp_t e;
        e = model(call, cpl, s, o, d, td);
        e.tag = tag;
        sb.push_back(e);
        tgt_desc    = td;
        req_is_call = call;
        req_cpl     = cpl;
        req_sel     = s;
        req_offset  = o;
        req_desc    = d;
        req_valid   = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (!busy) begin
            check(res_valid == 1'b1, {tag, " R10 one-cycle result"},
                  $sformatf("%0b", res_valid), "1");
        end else begin
            if (poke) begin
                req_desc  = code_d(1'b1, cpl, 1'b0);
                req_sel   = {13'h0005, 1'b0, cpl};
                req_valid = 1'b1;
                @(negedge clk);
                req_valid = 1'b0;
            end
            while (busy) @(negedge clk);
        end
    endtask

    // fetch responder
    initial begin
        forever begin
            @(negedge clk);
            if (fetch_req && !fetch_valid) begin
                fetch_cnt++;
                repeat (2) @(negedge clk);
                fetch_desc  = tgt_desc;
                fetch_valid = 1'b1;
                @(negedge clk);
                fetch_valid = 1'b0;
            end
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && res_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R10 unexpected result",
                      $sformatf("kind=%0d", res_kind), "none");
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(res_kind == e.kind && res_cs == e.cs && res_offset == e.off &&
                      res_count == e.cnt && res_cpl == e.cpl, e.tag,
                      $sformatf("k=%0d cs=%h off=%h n=%0d pl=%0d",
                                res_kind, res_cs, res_offset, res_count, res_cpl),
                      $sformatf("k=%0d cs=%h off=%h n=%0d pl=%0d",
                                e.kind, e.cs, e.off, e.cnt, e.cpl));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int fc;
        repeat (3) @(negedge clk);
        check(res_valid == 0 && busy == 0 && fetch_req == 0, "R12 reset state",
              $sformatf("%0b%0b%0b", res_valid, busy, fetch_req), "000");
        rst = 1'b0;
        @(negedge clk);

        // direct paths
        do_req(1, 2'd2, 16'h0122, 32'h0000_1000, code_d(1, 2'd2, 0), '0, 0, "R1 same level non-conforming");
        do_req(0, 2'd2, 16'h0123, 32'h0000_1000, code_d(1, 2'd2, 0), '0, 0, "R3 rpl above cpl");
        do_req(1, 2'd3, 16'h0043, 32'h0000_0200, code_d(1, 2'd0, 1), '0, 0, "R2 conforming more privileged");
        do_req(1, 2'd3, 16'h0040, 32'h0000_0200, code_d(1, 2'd0, 0), '0, 0, "R3 non-conforming more privileged");
        do_req(0, 2'd1, 16'h0041, 32'h0000_0200, code_d(1, 2'd3, 0), '0, 0, "R3 non-conforming less privileged");
        do_req(1, 2'd1, 16'h0041, 32'h0000_0200, code_d(1, 2'd3, 1), '0, 0, "R3 conforming less privileged");
        do_req(1, 2'd0, 16'h0040, 32'h0000_0200, data_d(1, 2'd0), '0, 0, "R3 data segment");
        do_req(1, 2'd0, 16'h0040, 32'h0000_0200, code_d(0, 2'd0, 0), '0, 0, "R3 not present");
        do_req(1, 2'd0, 16'h0040, 32'h0000_0200,
               {16'h0, 1'b1, 2'd3, 1'b0, 1'b0, 3'b101, 3'b000, 5'd0, 16'h0150, 16'h0},
               '0, 0, "R3 other system type");

        // gate paths
        do_req(1, 2'd1, 16'h0063, 32'h0,
               gate_d(1, 2'd3, 1, 16'h0150, 32'h1234_3400, 5'd2),
               code_d(1, 2'd0, 0), 0, "R7 call raise via 32-bit gate");
        fc = fetch_cnt;
        do_req(1, 2'd1, 16'h0063, 32'h0,
               gate_d(1, 2'd2, 1, 16'h0150, 32'h1234_3400, 5'd2),
               code_d(1, 2'd0, 0), 0, "R4 epl above gate dpl");
        check(fetch_cnt == fc, "R4 no fetch on rejected gate",
              $sformatf("%0d", fetch_cnt), $sformatf("%0d", fc));
        do_req(1, 2'd1, 16'h0061, 32'h0,
               gate_d(0, 2'd3, 1, 16'h0150, 32'h1234_3400, 5'd2),
               code_d(1, 2'd0, 0), 0, "R4 gate not present");
        do_req(0, 2'd2, 16'h0062, 32'h0,
               gate_d(1, 2'd3, 1, 16'h0150, 32'h0000_3400, 5'd4),
               code_d(1, 2'd0, 0), 0, "R8 jmp raise faults");
        do_req(0, 2'd1, 16'h0061, 32'h0,
               gate_d(1, 2'd1, 1, 16'h0150, 32'h0000_0800, 5'd4),
               code_d(1, 2'd1, 0), 0, "R8 jmp same level");
        do_req(1, 2'd1, 16'h0063, 32'h0,
               gate_d(1, 2'd3, 1, 16'h0150, 32'h0000_0800, 5'd4),
               code_d(1, 2'd3, 0), 0, "R5 target less privileged");
        do_req(1, 2'd1, 16'h0061, 32'h0,
               gate_d(1, 2'd3, 1, 16'h0150, 32'h0000_0800, 5'd4),
               data_d(1, 2'd0), 0, "R5 target is data");
        do_req(1, 2'd2, 16'h0062, 32'h0,
               gate_d(1, 2'd3, 1, 16'h0150, 32'h0000_0900, 5'd6),
               code_d(1, 2'd0, 1), 0, "R9 conforming target via gate");
        do_req(1, 2'd3, 16'h0063, 32'h0000_7777,
               gate_d(1, 2'd3, 0, 16'h015B, 32'hABCD_5678, 5'd7),
               code_d(1, 2'd0, 0), 0, "R6 16-bit gate and gate rpl ignored");
        fc = fetch_cnt;
        do_req(1, 2'd2, 16'h0062, 32'h0,
               gate_d(1, 2'd3, 1, 16'h0150, 32'h0000_3400, 5'd3),
               code_d(1, 2'd1, 0), 1, "R10 request during fetch ignored");
        check(fetch_cnt == fc + 1, "R10 single fetch while busy",
              $sformatf("%0d", fetch_cnt), $sformatf("%0d", fc + 1));

        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R10 all results delivered",
              $sformatf("%0d", sb.size()), "0");
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule